// File: doc/BRIEF.md
# Framed Byte-Exchange Serial Slave

This block is a serial-peripheral slave that moves exactly one byte per framed transaction between an external master and two internal byte FIFOs. Each frame is thirteen rising edges of the serial clock long. It carries a start bit, a direction bit, a target bit, eight data bits sent most significant bit first, and a trailing status bit. The status bit tells the master whether a write was accepted or whether the byte it read is meaningful.

The system side sees two first-word-fall-through FIFOs. A transmit FIFO is filled by the system and drained by master reads. A receive FIFO is filled by master writes and drained by the system. A third frame type returns an interface status byte that reports the fill state of both FIFOs.

The serial inputs are brought into the system clock domain by synchronizer stages, and the serial clock is oversampled. All FIFO traffic is therefore synchronous to `clk`. A frame that is cut short by a dropped select leaves both FIFOs untouched.

Top module: `framedSpiSlave`

## Requirements
- R1: After reset, `spiOut` is 0, `rxEmpty` is 1 and `txFull` is 0.
- R2: A frame begins only on a rising `spiClk` edge where both `spiSel` and `spiIn` are high. Rising edges with `spiIn` low while idle do nothing. Edges 2 and 3 of the frame carry the direction bit and then the target bit.
- R3: The setup pair (direction, target) selects the operation: (1,0) data read, (1,1) status read, (0,0) data write, (0,1) no operation. The no-operation frame changes no FIFO and returns data 0x00 with status bit 0.
- R4: In a data write, `spiIn` on edges 4 to 11 forms the byte, MSB first. `spiOut` carries status 1 between edges 11 and 12, and the byte enters the receive FIFO when edge 13 completes the frame.
- R5: A data write while the receive FIFO is full discards the byte, and the status bit is 0.
- R6: In a data read, `spiOut` holds the head byte of the transmit FIFO, MSB first: D7 from edge 3 to edge 4, down to D0 from edge 10 to edge 11. The status bit is 1 between edges 11 and 12, and the byte leaves the FIFO on edge 13.
- R7: A data read from an empty transmit FIFO returns 0x00 with status bit 0 and pops nothing.
- R8: A status read returns a byte with bit 0 = receive FIFO full, bit 1 = transmit FIFO non-empty, and bits 7..2 = 0. Its status bit is 1.
- R9: After a completed data or no-operation frame, start conditions are ignored until `spiSel` has been seen low. Status-read frames may follow each other with `spiSel` held high.
- R10: If `spiSel` drops before edge 13, the frame is aborted. Neither FIFO is pushed or popped, and the next frame starts cleanly.
- R11: `spiOut` is 0 whenever no frame is in progress.
- R12: Both FIFOs are first-in first-out with `FIFO_DEPTH` entries. A push to a full FIFO is ignored and so is a pop from an empty one. `txFull` and `rxEmpty` report the fill state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| spiClk | input | 1 | Serial clock from master |
| spiSel | input | 1 | Active-high select from master |
| spiIn | input | 1 | Serial data master to slave |
| spiOut | output | 1 | Serial data slave to master |
| txPush | input | 1 | Push `txData` into transmit FIFO |
| txData | input | 8 | Byte to queue for master reads |
| txFull | output | 1 | Transmit FIFO full |
| rxPop | input | 1 | Pop head of receive FIFO |
| rxData | output | 8 | Head of receive FIFO |
| rxEmpty | output | 1 | Receive FIFO empty |

## Verification
The assertions check the following on every cycle:
- the frame position only advances by one or returns to idle;
- `spiOut` is quiet while idle;
- a push never targets a full receive FIFO and a pop never targets an empty transmit FIFO;
- FIFO traffic happens only at the final edge of a frame.

The bench scenarios are needed to show the rest:
- the bit order of each byte;
- the encoding of the setup pair;
- the contents of the status byte;
- the lockout until select is released;
- that an aborted frame leaves the queued data intact;
- first-in first-out ordering across several frames.

// File: rtl/framedSpiPkg.sv
package framedSpiPkg;
  localparam int DATA_BITS = 8;
  localparam int POS_W = 4;

  // Frame position counts completed rising edges (0 = idle).
  localparam logic [POS_W-1:0] POS_IDLE = POS_W'(0);
  localparam logic [POS_W-1:0] POS_DIR = POS_W'(1);
  localparam logic [POS_W-1:0] POS_LOAD = POS_W'(2);
  localparam logic [POS_W-1:0] POS_FIRST_DATA = POS_W'(3);
  localparam logic [POS_W-1:0] POS_LAST_DATA = POS_W'(3 + DATA_BITS - 1);
  localparam logic [POS_W-1:0] POS_STATUS = POS_W'(3 + DATA_BITS);
  localparam logic [POS_W-1:0] POS_END = POS_W'(4 + DATA_BITS);

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_NONE = 2'b01,
    OP_READ = 2'b10,
    OP_STAT = 2'b11
  } opE;

  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_TX = 2'd1,
    LD_STAT = 2'd2,
    LD_ZERO = 2'd3
  } loadSelE;

  typedef struct packed {
    loadSelE loadSel;
    logic shiftEn;
    logic drvStatus;
    logic okBit;
    logic clearSdo;
    logic pushRx;
    logic popTx;
  } strobeT;
endpackage

// File: rtl/spiByteFifo.sv
module spiByteFifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic doPush, doPop;

  assign full = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign doPush = push && !full;
  assign doPop = pop && !empty;
  assign dout = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_SLOT) ? '0 : wrPtr + 1'b1;
      if (doPop) rdPtr <= (rdPtr == LAST_SLOT) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10: count <= count + 1'b1;
        2'b01: count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/framedSpiCtrl.sv
module framedSpiCtrl
  import framedSpiPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclkRise,
  input  logic             csS,
  input  logic             sdiS,
  input  logic             rxFull,
  input  logic             txEmpty,
  output strobeT           strb,
  output logic [POS_W-1:0] framePos
);
  logic [POS_W-1:0] pos;
  logic dirBit, addrBit, okFlag, needRel;
  opE op, opNow;
  logic okNow, startOk;

  assign op = opE'({dirBit, addrBit});
  assign opNow = opE'({dirBit, sdiS});
  assign okNow = (op == OP_WRITE) ? !rxFull : okFlag;
  assign startOk = csS && sdiS && !needRel;
  assign framePos = pos;

  always_comb begin
    strb = '0;
    if (!csS) begin
      strb.clearSdo = (pos != POS_IDLE);
    end else if (sclkRise) begin
      if (pos == POS_LOAD) begin
        case (opNow)
          OP_READ: strb.loadSel = LD_TX;
          OP_STAT: strb.loadSel = LD_STAT;
          default: strb.loadSel = LD_ZERO;
        endcase
      end
      if (pos >= POS_FIRST_DATA && pos <= POS_LAST_DATA) strb.shiftEn = 1'b1;
      if (pos == POS_LAST_DATA) begin
        strb.drvStatus = 1'b1;
        strb.okBit = okNow;
      end
      if (pos == POS_END) begin
        strb.pushRx = (op == OP_WRITE) && okFlag;
        strb.popTx = (op == OP_READ) && okFlag;
        strb.clearSdo = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos <= POS_IDLE;
      dirBit <= 1'b0;
      addrBit <= 1'b0;
      okFlag <= 1'b0;
      needRel <= 1'b0;
    end else begin
      if (!csS) needRel <= 1'b0;
      else if (sclkRise && pos == POS_END && op != OP_STAT) needRel <= 1'b1;

      if (!csS) begin
        pos <= POS_IDLE;
      end else if (sclkRise) begin
        if (pos == POS_IDLE) begin
          if (startOk) pos <= POS_DIR;
        end else if (pos == POS_END) begin
          pos <= POS_IDLE;
        end else begin
          pos <= pos + 1'b1;
        end
        if (pos == POS_DIR) dirBit <= sdiS;
        if (pos == POS_LOAD) begin
          addrBit <= sdiS;
          okFlag <= (opNow == OP_READ) ? !txEmpty : (opNow == OP_STAT);
        end
        if (pos == POS_LAST_DATA) okFlag <= okNow;
      end
    end
  end
endmodule

// File: rtl/framedSpiDatapath.sv
module framedSpiDatapath
  import framedSpiPkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 spiClk,
  input  logic                 spiSel,
  input  logic                 spiIn,
  output logic                 spiOut,
  input  strobeT               strb,
  output logic                 sclkRise,
  output logic                 csS,
  output logic                 sdiS,
  output logic                 rxFull,
  output logic                 txEmpty,
  input  logic                 txPush,
  input  logic [DATA_BITS-1:0] txData,
  output logic                 txFull,
  input  logic                 rxPop,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxEmpty
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sclkPipe, csPipe, sdiPipe;
  logic sclkPrev;
  logic [DATA_BITS-1:0] shReg, txHead, statByte, loadVal;

  // Synchronizers: all three inputs see the same delay.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe <= '0;
      sdiPipe <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkPipe <= {sclkPipe[TOP-1:0], spiClk};
      csPipe <= {csPipe[TOP-1:0], spiSel};
      sdiPipe <= {sdiPipe[TOP-1:0], spiIn};
      sclkPrev <= sclkPipe[TOP];
    end
  end

  assign sclkRise = sclkPipe[TOP] && !sclkPrev;
  assign csS = csPipe[TOP];
  assign sdiS = sdiPipe[TOP];

  assign statByte = {{(DATA_BITS-2){1'b0}}, !txEmpty, rxFull};

  always_comb begin
    case (strb.loadSel)
      LD_TX: loadVal = txEmpty ? '0 : txHead;
      LD_STAT: loadVal = statByte;
      default: loadVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
      spiOut <= 1'b0;
    end else begin
      if (strb.loadSel != LD_NONE) shReg <= loadVal;
      else if (strb.shiftEn) shReg <= {shReg[DATA_BITS-2:0], sdiS};

      if (strb.clearSdo) spiOut <= 1'b0;
      else if (strb.drvStatus) spiOut <= strb.okBit;
      else if (strb.loadSel != LD_NONE) spiOut <= loadVal[DATA_BITS-1];
      else if (strb.shiftEn) spiOut <= shReg[DATA_BITS-2];
    end
  end

  spiByteFifo #(.WIDTH(DATA_BITS), .DEPTH(FIFO_DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN),
    .push(strb.pushRx), .pop(rxPop),
    .din(shReg), .dout(rxData),
    .full(rxFull), .empty(rxEmpty)
  );

  spiByteFifo #(.WIDTH(DATA_BITS), .DEPTH(FIFO_DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN),
    .push(txPush), .pop(strb.popTx),
    .din(txData), .dout(txHead),
    .full(txFull), .empty(txEmpty)
  );
endmodule

// File: rtl/framedSpiSlave.sv
module framedSpiSlave
  import framedSpiPkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiClk,
  input  logic       spiSel,
  input  logic       spiIn,
  output logic       spiOut,
  input  logic       txPush,
  input  logic [7:0] txData,
  output logic       txFull,
  input  logic       rxPop,
  output logic [7:0] rxData,
  output logic       rxEmpty
);
  strobeT strb;
  logic [POS_W-1:0] framePos;
  logic sclkRise, csS, sdiS, rxFullW, txEmptyW;

  framedSpiCtrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .sclkRise(sclkRise), .csS(csS), .sdiS(sdiS),
    .rxFull(rxFullW), .txEmpty(txEmptyW),
    .strb(strb), .framePos(framePos)
  );

  framedSpiDatapath #(.FIFO_DEPTH(FIFO_DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN),
    .spiClk(spiClk), .spiSel(spiSel), .spiIn(spiIn), .spiOut(spiOut),
    .strb(strb),
    .sclkRise(sclkRise), .csS(csS), .sdiS(sdiS),
    .rxFull(rxFullW), .txEmpty(txEmptyW),
    .txPush(txPush), .txData(txData), .txFull(txFull),
    .rxPop(rxPop), .rxData(rxData), .rxEmpty(rxEmpty)
  );
endmodule

// File: rtl/framedSpiChecker.sv
module framedSpiChecker
  import framedSpiPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [POS_W-1:0] framePos,
  input strobeT           strb,
  input logic             rxFullW,
  input logic             txEmptyW,
  input logic             spiOut
);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (framePos == POS_IDLE) |-> !spiOut);

  assert_no_full_push_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushRx |-> !rxFullW);

  assert_no_empty_pop_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.popTx |-> !txEmptyW);

  assert_push_at_end_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pushRx || strb.popTx) |-> (framePos == POS_END));

  assert_one_fifo_op_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.pushRx, strb.popTx}));

  assert_pos_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (framePos != POS_IDLE) |=> (framePos == POS_IDLE || framePos == $past(framePos)
                                 || framePos == $past(framePos) + 1'b1));

  assert_pos_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    framePos <= POS_END);
endmodule

bind framedSpiSlave framedSpiChecker u_chk (
  .clk(clk), .rstN(rstN), .framePos(framePos), .strb(strb),
  .rxFullW(rxFullW), .txEmptyW(txEmptyW), .spiOut(spiOut)
);

// File: tb/framedSpiSlave_bench.sv
module framedSpiSlave_bench;
  localparam int DEPTH = 4;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiClk = 1'b0, spiSel = 1'b0, spiIn = 1'b0;
  logic spiOut;
  logic txPush = 1'b0, rxPop = 1'b0;
  logic [7:0] txData = '0;
  logic txFull, rxEmpty;
  logic [7:0] rxData;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  framedSpiSlave #(.FIFO_DEPTH(DEPTH)) u_framedSpiSlave (
    .clk(clk), .rstN(rstN),
    .spiClk(spiClk), .spiSel(spiSel), .spiIn(spiIn), .spiOut(spiOut),
    .txPush(txPush), .txData(txData), .txFull(txFull),
    .rxPop(rxPop), .rxData(rxData), .rxEmpty(rxEmpty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic dv, output logic ov);
    spiIn = dv;
    repeat (HALF) @(negedge clk);
    ov = spiOut;
    spiClk = 1'b1;
    repeat (HALF) @(negedge clk);
    spiClk = 1'b0;
  endtask

  task automatic frame(input bit dir, input bit adr, input logic [7:0] wv, input int nRises,
                       output logic [7:0] rv, output logic st);
    logic o;
    logic b;
    rv = '0;
    st = 1'b0;
    spiSel = 1'b1;
    for (int k = 1; k <= nRises; k++) begin
      if (k == 1) b = 1'b1;
      else if (k == 2) b = dir;
      else if (k == 3) b = adr;
      else if (k <= 11) b = wv[11-k];
      else b = 1'b0;
      tick(b, o);
      if (k >= 4 && k <= 11) rv[11-k] = o;
      if (k == 12) st = o;
    end
  endtask

  task automatic release_cs();
    logic o;
    spiSel = 1'b0;
    tick(1'b0, o);
  endtask

  task automatic pushTx(input logic [7:0] v);
    txData = v;
    txPush = 1'b1;
    @(negedge clk);
    txPush = 1'b0;
  endtask

  task automatic popRx();
    rxPop = 1'b1;
    @(negedge clk);
    rxPop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    logic st;
    logic o;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(spiOut == 1'b0, "R1 sdo", spiOut, 0);
    chk(rxEmpty == 1'b1, "R1 rxEmpty", rxEmpty, 1);
    chk(txFull == 1'b0, "R1 txFull", txFull, 0);

    // R2: idle rises with data low start nothing; R11 output stays low
    spiSel = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick(1'b0, o);
      chk(o == 1'b0, "R11 idle sdo", o, 0);
    end
    spiSel = 1'b0;

    // R4 write sweep over all byte values
    for (int v = 0; v < 256; v++) begin
      frame(1'b0, 1'b0, 8'(v), 13, rv, st);
      release_cs();
      chk(st == 1'b1, "R4 write status", st, 1);
      chk(!rxEmpty && rxData == 8'(v), "R4 write data", rxData, v);
      popRx();
    end
    chk(rxEmpty == 1'b1, "R12 rx drained", rxEmpty, 1);

    // R6 read sweep over all byte values
    for (int v = 0; v < 256; v++) begin
      pushTx(8'(255 - v));
      frame(1'b1, 1'b0, 8'h00, 13, rv, st);
      release_cs();
      chk(rv == 8'(255 - v), "R6 read data", rv, 255 - v);
      chk(st == 1'b1, "R6 read status", st, 1);
    end

    // R7 read from empty
    frame(1'b1, 1'b0, 8'hFF, 13, rv, st);
    release_cs();
    chk(rv == 8'h00, "R7 empty data", rv, 0);
    chk(st == 1'b0, "R7 empty status", st, 0);

    // R8 status byte across fill combinations
    for (int c = 0; c < 4; c++) begin
      bit wantRxFull = c[0];
      bit wantTx = c[1];
      if (wantRxFull) begin
        for (int i = 0; i < DEPTH; i++) begin
          frame(1'b0, 1'b0, 8'(i + 8'h40), 13, rv, st);
          release_cs();
        end
      end
      if (wantTx) pushTx(8'hC3);
      frame(1'b1, 1'b1, 8'h00, 13, rv, st);
      chk(rv == {6'b0, wantTx, wantRxFull}, "R8 status byte", rv, {6'b0, wantTx, wantRxFull});
      chk(st == 1'b1, "R8 status bit", st, 1);
      // R9 back-to-back status reads without release
      frame(1'b1, 1'b1, 8'h00, 13, rv, st);
      chk(rv == {6'b0, wantTx, wantRxFull} && st, "R9 status repeat", rv, {6'b0, wantTx, wantRxFull});
      release_cs();
      if (wantRxFull) begin
        // R5 write into full FIFO is dropped
        frame(1'b0, 1'b0, 8'hEE, 13, rv, st);
        release_cs();
        chk(st == 1'b0, "R5 full status", st, 0);
        for (int i = 0; i < DEPTH; i++) begin
          chk(!rxEmpty && rxData == 8'(i + 8'h40), "R12 rx order", rxData, i + 8'h40);
          popRx();
        end
        chk(rxEmpty == 1'b1, "R5 dropped byte absent", rxEmpty, 1);
      end
      if (wantTx) begin
        frame(1'b1, 1'b0, 8'h00, 13, rv, st);
        release_cs();
        chk(rv == 8'hC3 && st, "R6 drain", rv, 8'hC3);
      end
    end

    // R12 transmit FIFO fill, overflow ignored, order kept
    for (int i = 0; i < DEPTH + 1; i++) pushTx(8'(8'h10 + i));
    chk(txFull == 1'b1, "R12 txFull", txFull, 1);
    for (int i = 0; i < DEPTH; i++) begin
      frame(1'b1, 1'b0, 8'h00, 13, rv, st);
      release_cs();
      chk(rv == 8'(8'h10 + i) && st, "R12 tx order", rv, 8'h10 + i);
    end
    frame(1'b1, 1'b0, 8'h00, 13, rv, st);
    release_cs();
    chk(rv == 8'h00 && !st, "R12 tx overflow ignored", rv, 0);
    popRx();
    chk(rxEmpty == 1'b1, "R12 rx underflow ignored", rxEmpty, 1);

    // R3 unused setup pair
    pushTx(8'h9A);
    frame(1'b0, 1'b1, 8'h55, 13, rv, st);
    release_cs();
    chk(rv == 8'h00 && !st, "R3 noop reply", {st, rv}, 0);
    chk(rxEmpty == 1'b1, "R3 noop no push", rxEmpty, 1);

    // R10 aborted read keeps the byte queued
    frame(1'b1, 1'b0, 8'h00, 8, rv, st);
    release_cs();
    chk(spiOut == 1'b0, "R11 sdo after abort", spiOut, 0);
    frame(1'b1, 1'b0, 8'h00, 13, rv, st);
    release_cs();
    chk(rv == 8'h9A && st, "R10 read after abort", rv, 8'h9A);

    // R10 aborted write after status edge pushes nothing
    frame(1'b0, 1'b0, 8'h77, 12, rv, st);
    release_cs();
    chk(rxEmpty == 1'b1, "R10 write abort", rxEmpty, 1);

    // R9 no new data frame until select released
    frame(1'b0, 1'b0, 8'h3C, 13, rv, st);
    frame(1'b0, 1'b0, 8'hA5, 13, rv, st);
    chk(rv == 8'h00 && !st, "R9 locked frame reply", {st, rv}, 0);
    release_cs();
    chk(!rxEmpty && rxData == 8'h3C, "R9 first write", rxData, 8'h3C);
    popRx();
    chk(rxEmpty == 1'b1, "R9 locked write absent", rxEmpty, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule